// File: doc/BRIEF.md
# Timer-Triggered Pattern Output Port

This block drives an 8-bit output port that changes only on a timer event. An up-counter runs once it is started and compares its value with a period register. When the two are equal, the counter returns to zero and a match event fires. That event copies a software-loaded next-pattern buffer into the output latch. Only bits that are enabled in a per-bit mask are copied, and only nibbles whose trigger-select field names this timer channel take part.

The match also sets a status flag. An interrupt request is raised from that flag when its enable bit is set. Software or a DMA engine answers each request by loading the following pattern into the buffer. Because the port is double-buffered, the output steps through a sequence with timer precision. A repeating five-phase overlapping pulse train is one example. The registers are accessed through a simple synchronous bus. Writes take effect at the clock edge, and reads are combinational.

Top module: `pulse_pattern_out`

## Requirements
- R1: A match occurs when the running counter equals the period value; the counter then restarts at 0, so a period value P gives one match every P+1 clocks. The period is split over address 2 (low byte) and address 3 (high byte).
- R2: On a match, each enabled bit of the next-pattern buffer (address 4) is copied into the output latch, visible on `pat_out` after that edge; with no match and no direct write the output holds.
- R3: `irq` is high exactly when the status flag (address 1, bit 0) is 1 and the interrupt enable (address 0, bit 1) is 1.
- R4: The enable mask (address 5) gates the copy bit by bit; disabled bits keep the latch value, which a write to address 6 sets directly.
- R5: The group-select register (address 7) holds a 2-bit field per nibble: bits [1:0] for `pat_out[3:0]`, bits [3:2] for `pat_out[7:4]`; only nibbles whose field equals the channel code (default 1) update on a match.
- R6: The counter stays at 0 and no match occurs while the start bit (address 0, bit 0) is 0; after start, the first pattern appears only at the first match.
- R7: With mask 0xF8, buffer preloaded with 0x80 and then written with 0xC0, 0x40, 0x60, 0x20, 0x30, 0x10, 0x18, 0x08, 0x88 at successive matches, the port repeats that ten-step five-phase sequence.
- R8: A buffer write in the same clock as a match is used by the following match; the current match copies the older value.
- R9: Every match sets the status flag. Writing 0 to bit 0 clears the flag only if the flag was read as 1 since the last status write. A match in the clearing cycle keeps the flag set.
- R10: A period value of 0 gives a match on every clock while running, so the port follows the buffer one clock behind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (arms the flag clear) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pat_out | output | 8 | Pattern output port |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check the following. The counter steps by one or restarts, and it sits at zero when stopped. The port holds between events. Masked bits and unselected nibbles are never touched by a match. Every match leaves the flag set, an unarmed clear cannot drop it, and `irq` stays low while disabled. Only the bench's scenarios can show the full sequence behaviour: the exact P+1 spacing from start to the first output, the ten-step five-phase output driven by interrupt service, the one-event delay of a buffer write that collides with a match, and the read-then-write clear protocol.

// File: rtl/ppo_pkg.sv
`timescale 1ns/1ps
package ppo_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_STAT   = 3'd1,
    A_PER_LO = 3'd2,
    A_PER_HI = 3'd3,
    A_NEXT   = 3'd4,
    A_MASK   = 3'd5,
    A_OUT    = 3'd6,
    A_GRP    = 3'd7
  } reg_addr_e;

  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_IE_BIT  = 1;
  localparam int STAT_FLG_BIT = 0;
endpackage

// File: rtl/ppo_timer.sv
`timescale 1ns/1ps
module ppo_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period,
  output logic             match
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign match = run && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (match)  cnt_q <= '0;
    else             cnt_q <= step(cnt_q);
  end

  p_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (cnt_q == '0));
  p_count_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !match) |=> (cnt_q == step($past(cnt_q))));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !match);
  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/ppo_latch.sv
`timescale 1ns/1ps
module ppo_latch #(
  parameter int               PORT_W  = 8,
  parameter int               GRP_W   = 4,
  parameter int               SEL_W   = 2,
  parameter int               NGRP    = PORT_W / GRP_W,
  parameter logic [SEL_W-1:0] CHAN_ID = 2'd1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  match,
  input  logic [PORT_W-1:0]     next_q,
  input  logic [PORT_W-1:0]     mask,
  input  logic [NGRP*SEL_W-1:0] grp_sel,
  input  logic                  out_we,
  input  logic [PORT_W-1:0]     out_wdata,
  output logic [PORT_W-1:0]     pins
);
  logic [PORT_W-1:0] grp_bits;
  logic [PORT_W-1:0] xfer_en;
  logic [PORT_W-1:0] base;

  function automatic logic [PORT_W-1:0] merge(input logic [PORT_W-1:0] cur,
                                              input logic [PORT_W-1:0] nxt,
                                              input logic [PORT_W-1:0] en);
    return (cur & ~en) | (nxt & en);
  endfunction

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_bits[g*GRP_W +: GRP_W] =
      {GRP_W{grp_sel[g*SEL_W +: SEL_W] == CHAN_ID}};

    p_grp_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (match && !out_we && (grp_sel[g*SEL_W +: SEL_W] != CHAN_ID))
      |=> $stable(pins[g*GRP_W +: GRP_W]));
  end

  assign xfer_en = match ? (mask & grp_bits) : '0;
  assign base    = out_we ? out_wdata : pins;

  always_ff @(posedge clk) begin
    if (!rst_n) pins <= '0;
    else        pins <= merge(base, next_q, xfer_en);
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!match && !out_we) |=> $stable(pins));
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !out_we) |=> (((pins ^ $past(pins)) & ~$past(mask)) == '0));
  p_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> (((pins ^ $past(next_q)) & $past(mask & grp_bits)) == '0));
endmodule

// File: rtl/pulse_pattern_out.sv
`timescale 1ns/1ps
module pulse_pattern_out #(
  parameter int         PORT_W  = 8,
  parameter int         CNT_W   = 16,
  parameter logic [1:0] CHAN_ID = 2'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [2:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  output logic [PORT_W-1:0] pat_out,
  output logic              irq
);
  import ppo_pkg::*;

  localparam int GRP_W = 4;
  localparam int SEL_W = 2;
  localparam int NGRP  = PORT_W / GRP_W;
  localparam int HI_W  = CNT_W - PORT_W;

  logic                  run_q, ie_q, flag_q, armed_q;
  logic [CNT_W-1:0]      per_q;
  logic [PORT_W-1:0]     next_q, mask_q;
  logic [NGRP*SEL_W-1:0] grp_q;
  logic                  match;
  reg_addr_e             sel;
  logic                  wr_stat, rd_stat, clr_req, out_we;
  logic [2*PORT_W-1:0]   per_ext;

  assign sel     = reg_addr_e'(bus_addr);
  assign wr_stat = bus_we && (sel == A_STAT);
  assign rd_stat = bus_re && (sel == A_STAT);
  assign clr_req = wr_stat && !bus_wdata[STAT_FLG_BIT] && armed_q;
  assign out_we  = bus_we && (sel == A_OUT);
  assign per_ext = (2*PORT_W)'(per_q);
  assign irq     = flag_q && ie_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      per_q  <= '0;
      next_q <= '0;
      mask_q <= '0;
      grp_q  <= '0;
    end else if (bus_we) begin
      case (sel)
        A_CTRL: begin
          run_q <= bus_wdata[CTRL_RUN_BIT];
          ie_q  <= bus_wdata[CTRL_IE_BIT];
        end
        A_PER_LO: per_q[PORT_W-1:0]     <= bus_wdata;
        A_PER_HI: per_q[CNT_W-1:PORT_W] <= bus_wdata[HI_W-1:0];
        A_NEXT:   next_q <= bus_wdata;
        A_MASK:   mask_q <= bus_wdata;
        A_GRP:    grp_q  <= bus_wdata[NGRP*SEL_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (match)        flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (wr_stat)                armed_q <= 1'b0;
      else if (rd_stat && flag_q) armed_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel)
      A_CTRL:   begin
        bus_rdata[CTRL_RUN_BIT] = run_q;
        bus_rdata[CTRL_IE_BIT]  = ie_q;
      end
      A_STAT:   bus_rdata[STAT_FLG_BIT] = flag_q;
      A_PER_LO: bus_rdata = per_ext[PORT_W-1:0];
      A_PER_HI: bus_rdata = per_ext[2*PORT_W-1:PORT_W];
      A_NEXT:   bus_rdata = next_q;
      A_MASK:   bus_rdata = mask_q;
      A_OUT:    bus_rdata = pat_out;
      A_GRP:    bus_rdata = PORT_W'(grp_q);
      default:  bus_rdata = '0;
    endcase
  end

  ppo_timer #(.CNT_W(CNT_W)) timer_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run_q),
    .period (per_q),
    .match  (match)
  );

  ppo_latch #(
    .PORT_W  (PORT_W),
    .GRP_W   (GRP_W),
    .SEL_W   (SEL_W),
    .NGRP    (NGRP),
    .CHAN_ID (CHAN_ID)
  ) latch_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .match     (match),
    .next_q    (next_q),
    .mask      (mask_q),
    .grp_sel   (grp_q),
    .out_we    (out_we),
    .out_wdata (bus_wdata),
    .pins      (pat_out)
  );

  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag_q);
  p_unarmed_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !armed_q) |=> flag_q);
  p_irq_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ie_q |-> !irq);
endmodule

// File: tb/pulse_pattern_out_tb.sv
`timescale 1ns/1ps
module pulse_pattern_out_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata, pat_out;
  logic       irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  localparam logic [2:0] CTRL = 3'd0, STAT = 3'd1, PLO = 3'd2, PHI = 3'd3,
                         NXT = 3'd4, MSK = 3'd5, OUTR = 3'd6, GRP = 3'd7;

  always #4 clk = ~clk;

  pulse_pattern_out dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pat_out(pat_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_re = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_flag();
    logic [7:0] d;
    rd(STAT, d);
    wr(STAT, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk("R2 reset out", pat_out, 8'h00);
    chk("R3 reset irq", irq, 1'b0);
    rd(STAT, d); chk("R9 reset flag", d, 8'h00);
    rd(CTRL, d); chk("R6 reset ctrl", d, 8'h00);
  endtask

  task automatic t_start();
    int n;
    wr(MSK, 8'hFF); wr(GRP, 8'h05); wr(NXT, 8'h81);
    wr(PLO, 8'h05); wr(PHI, 8'h00);
    cyc(20);
    chk("R6 no output before start", pat_out, 8'h00);
    chk("R6 no irq before start", irq, 1'b0);
    wr(CTRL, 8'h03);
    n = 0;
    while (pat_out != 8'h81 && n < 50) begin
      @(posedge clk); #1; n++;
    end
    chk("R1 R6 clocks to first match", 16'(n), 16'd6);
    chk("R3 irq after match", irq, 1'b1);
    wr(CTRL, 8'h00);
    clear_flag();
  endtask

  task automatic t_mask();
    logic [7:0] d;
    int n;
    wr(GRP, 8'h05); wr(MSK, 8'hF0); wr(OUTR, 8'h05);
    chk("R4 direct latch write", pat_out, 8'h05);
    wr(NXT, 8'hAA); wr(PLO, 8'h02); wr(CTRL, 8'h01);
    n = 0;
    while (pat_out == 8'h05 && n < 20) begin
      @(posedge clk); #1; n++;
    end
    chk("R4 masked copy", pat_out, 8'hA5);
    chk("R3 irq gated by enable", irq, 1'b0);
    rd(STAT, d); chk("R3 flag set while disabled", d, 8'h01);
    wr(CTRL, 8'h00);
  endtask

  task automatic t_group();
    int n;
    wr(OUTR, 8'h00); wr(MSK, 8'hFF); wr(GRP, 8'h0D);
    wr(NXT, 8'h3C); wr(PLO, 8'h02); wr(CTRL, 8'h01);
    n = 0;
    while (pat_out == 8'h00 && n < 20) begin
      @(posedge clk); #1; n++;
    end
    cyc(3);
    chk("R5 only selected nibble", pat_out, 8'h0C);
    wr(CTRL, 8'h00);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    rd(STAT, d);
    wr(STAT, 8'h00);
    rd(STAT, d); chk("R9 armed clear", d, 8'h00);
    wr(PLO, 8'h00); wr(PHI, 8'h00);
    wr(CTRL, 8'h01); wr(CTRL, 8'h00);
    wr(STAT, 8'h00);
    rd(STAT, d); chk("R9 unarmed clear ignored", d, 8'h01);
    wr(STAT, 8'h00);
    rd(STAT, d); chk("R9 clear after read", d, 8'h00);
    wr(CTRL, 8'h03);
    rd(STAT, d);
    wr(STAT, 8'h00);
    chk("R9 match wins over clear irq", irq, 1'b1);
    rd(STAT, d); chk("R9 match wins over clear flag", d, 8'h01);
    wr(CTRL, 8'h00);
    chk("R3 irq low when disabled", irq, 1'b0);
    clear_flag();
  endtask

  task automatic t_period0();
    wr(MSK, 8'hFF); wr(GRP, 8'h05); wr(NXT, 8'h11); wr(OUTR, 8'h00);
    wr(PLO, 8'h00); wr(PHI, 8'h00);
    wr(CTRL, 8'h01);
    chk("R6 start edge no copy", pat_out, 8'h00);
    wr(NXT, 8'h22);
    chk("R8 colliding write not used", pat_out, 8'h11);
    cyc(1);
    chk("R10 R8 next clock copies new value", pat_out, 8'h22);
    wr(NXT, 8'h33);
    chk("R10 still previous", pat_out, 8'h22);
    cyc(1);
    chk("R10 every clock", pat_out, 8'h33);
    wr(CTRL, 8'h00);
    clear_flag();
  endtask

  task automatic t_five();
    logic [7:0] seq [10] = '{8'h80, 8'hC0, 8'h40, 8'h60, 8'h20,
                             8'h30, 8'h10, 8'h18, 8'h08, 8'h88};
    wr(MSK, 8'hF8); wr(GRP, 8'h05); wr(OUTR, 8'h00);
    wr(PLO, 8'h09); wr(PHI, 8'h00); wr(NXT, seq[0]);
    clear_flag();
    wr(CTRL, 8'h03);
    chk("R6 nothing at start", pat_out, 8'h00);
    for (int i = 0; i < 12; i++) begin
      int n = 0;
      while (!irq && n < 40) begin
        @(posedge clk); #1; n++;
      end
      chk($sformatf("R7 step %0d", i), pat_out, seq[i % 10]);
      wr(NXT, seq[(i + 1) % 10]);
      clear_flag();
      chk($sformatf("R2 hold step %0d", i), pat_out, seq[i % 10]);
    end
    wr(CTRL, 8'h00);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_start();
    t_mask();
    t_group();
    t_flag();
    t_period0();
    t_five();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule